// File: doc/BRIEF.md
# Retriggerable Delay and Lockout Controller

This block turns an already-qualified trigger level into a timed control pulse, as in the output stage of a motion-sensing light or alarm controller. A rising edge on the trigger input, accepted while the arm input is high, drives the control output high for a hold interval. The hold interval is given as a count of clock cycles. When the output falls, a lockout interval follows during which every trigger is discarded. The lockout length is also given in clock cycles. After the lockout expires, the block waits for the next edge.

A mode input chooses how an edge is handled while the output is already high. In extend mode the hold interval restarts from that edge. In fixed mode the edge is dropped, so the pulse ends a fixed time after it began. The trigger is resynchronised to the block clock, and only its rising edge counts. A trigger that is held high therefore produces a single pulse.

Top module: `retrig_lockout_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output is low after that edge, both timers are cleared and the controller is idle. After release, the next accepted edge starts a normal pulse with no lockout.
- R2: A 0-to-1 change on `trig_in` made between clock edges k and k+1, with `arm_in` high and the controller idle, makes `ctrl_out` high after edge k+3. The three edges are two synchroniser flops and the state register.
- R3: Without retriggering, `ctrl_out` stays high for exactly `hold_cycles` clock cycles.
- R4: With `retrig_mode` = 1, an edge with `arm_in` high that arrives while the output is high restarts the hold count. The output then falls `hold_cycles` cycles after the edge is acted on. This also holds when the edge is acted on in the last high cycle.
- R5: With `retrig_mode` = 0, edges that arrive while the output is high have no effect, and the pulse length stays `hold_cycles`.
- R6: After the output falls, the controller spends exactly `lock_cycles` cycles in lockout and ignores every edge during that time. An edge acted on in the first cycle after the lockout is accepted.
- R7: An edge that is detected while `arm_in` is low is discarded. It is not stored, and raising `arm_in` later does not start a pulse.
- R8: `arm_in` is sampled only when an edge is detected. Lowering it during a pulse does not shorten the pulse. In extend mode, an edge seen while `arm_in` is low does not extend the pulse.
- R9: A `hold_cycles` or `lock_cycles` value of 0 acts as a count of 1 cycle.
- R10: Only rising edges trigger. A trigger held high does not start a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Qualified trigger level, asynchronous to `clk` |
| arm_in | input | 1 | 1 allows triggers, 0 rejects them |
| retrig_mode | input | 1 | 1 = edges during the pulse extend it, 0 = they are ignored |
| hold_cycles | input | 16 | Pulse length in clock cycles (0 counts as 1) |
| lock_cycles | input | 16 | Lockout length in clock cycles (0 counts as 1) |
| ctrl_out | output | 1 | Control pulse output |

## Verification
Some rules are checked on every cycle by the assertions. These are:
- the reset clearing the output;
- every rise of the output following an armed edge;
- a running hold count keeping the output high;
- an expired hold count ending the pulse unless an armed extend-mode edge is present;
- a pending lockout count keeping the output low.

Other properties can only be shown by the bench scenarios. These are:
- the exact three-edge latency from the trigger pin;
- the exact pulse lengths after one or two retriggers;
- the boundary cycle at which lockout stops rejecting edges;
- discarded edges that stay discarded when the arm input rises later;
- the zero-count cases.

// File: rtl/rlc_pkg.sv
// Package: shared types for the retriggerable delay and lockout controller.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package rlc_pkg;

    // Controller phases: waiting, output asserted, post-pulse trigger rejection.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOCK = 2'd2
    } rlc_state_t;

endpackage

// File: rtl/trig_sync.sv
// Module: trig_sync
// Resynchronises an asynchronous trigger level through a chain of STAGES
// flops and emits a single-cycle pulse on each rising edge of the
// synchronised level.
// Assumes: STAGES >= 2, synchronous active-low reset clears the chain to 0.
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              level_q;

    // Shift the raw input into the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= chain[STAGES-1];
        end
    end

    // A rising edge is a synchronised 1 that was 0 a cycle earlier.
    assign rise = chain[STAGES-1] & ~level_q;

endmodule

// File: rtl/cycle_timer.sv
// Module: cycle_timer
// Down-counter for an interval of cycles. A load starts the interval with
// the programmed count minus one, so it reaches zero after that many
// cycles. A programmed count of zero is treated as one. While run is high
// and the counter is not at zero, it decrements.
// Assumes: load has priority over run; reset clears the count to zero.
module cycle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         at_zero
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic [W-1:0] start_val;

    // Convert the programmed length into the first remaining-cycle value.
    always_comb begin
        start_val = (load_val == '0) ? '0 : (load_val - ONE);
    end

    // Load, count down, or hold the remaining-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= start_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end

    assign at_zero = (cnt == '0);

endmodule

// File: rtl/rlc_fsm.sv
// Module: rlc_fsm
// Sequencer for the controller: idle -> hold on an armed edge, hold -> lockout
// when the hold timer expires (unless an armed extend-mode edge reloads it),
// lockout -> idle when the lockout timer expires.
// Assumes: timer at_zero flags reflect the count before this edge; the arm
// and mode inputs are looked at only when an edge is present.
module rlc_fsm
    import rlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic arm,
    input  logic retrig,
    input  logic hold_zero,
    input  logic lock_zero,
    output logic hold_load,
    output logic hold_run,
    output logic lock_load,
    output logic lock_run,
    output logic out_high
);

    rlc_state_t state, state_nx;
    logic       accept;

    // An edge counts only if the arm input allows it at that moment.
    assign accept = rise & arm;

    // Next-state and timer control decode.
    always_comb begin
        state_nx  = state;
        hold_load = 1'b0;
        hold_run  = 1'b0;
        lock_load = 1'b0;
        lock_run  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx  = ST_HOLD;
                    hold_load = 1'b1;
                end
            end
            ST_HOLD: begin
                if (accept && retrig) begin
                    hold_load = 1'b1;
                end else if (hold_zero) begin
                    state_nx  = ST_LOCK;
                    lock_load = 1'b1;
                end else begin
                    hold_run  = 1'b1;
                end
            end
            ST_LOCK: begin
                if (lock_zero) begin
                    state_nx = ST_IDLE;
                end else begin
                    lock_run = 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign out_high = (state == ST_HOLD);

endmodule

// File: rtl/retrig_lockout_ctrl.sv
// Module: retrig_lockout_ctrl (top)
// Timed control pulse from a qualified trigger, with selectable extend or
// fixed behaviour and a lockout window after each pulse.
// Assumes: trig_in may be asynchronous; arm_in, retrig_mode and the
// cycle-count inputs are synchronous to clk; reset is synchronous, active low.
module retrig_lockout_ctrl #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             arm_in,
    input  logic             retrig_mode,
    input  logic [CNT_W-1:0] hold_cycles,
    input  logic [CNT_W-1:0] lock_cycles,
    output logic             ctrl_out
);

    logic trig_rise;
    logic hold_load, hold_run, hold_zero;
    logic lock_load, lock_run, lock_zero;

    trig_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_in),
        .rise  (trig_rise)
    );

    cycle_timer #(
        .W (CNT_W)
    ) u_hold_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_cycles),
        .run      (hold_run),
        .at_zero  (hold_zero)
    );

    cycle_timer #(
        .W (CNT_W)
    ) u_lock_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_load),
        .load_val (lock_cycles),
        .run      (lock_run),
        .at_zero  (lock_zero)
    );

    rlc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (trig_rise),
        .arm       (arm_in),
        .retrig    (retrig_mode),
        .hold_zero (hold_zero),
        .lock_zero (lock_zero),
        .hold_load (hold_load),
        .hold_run  (hold_run),
        .lock_load (lock_load),
        .lock_run  (lock_run),
        .out_high  (ctrl_out)
    );

endmodule

// File: rtl/rlc_checker.sv
// Module: rlc_checker
// Cycle-by-cycle property checks for retrig_lockout_ctrl, attached by bind.
// Assumes: it observes the internal edge pulse and the timer zero flags.
module rlc_checker (
    input logic clk,
    input logic rst_n,
    input logic ctrl_out,
    input logic rise,
    input logic arm,
    input logic retrig,
    input logic hold_zero,
    input logic lock_zero
);

    logic rst_seen = 1'b0;

    // Record whether reset was applied at the previous edge.
    always @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R1: one edge after reset, the output must be low.
    always @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_clears_R1: assert (!ctrl_out)
                else $error("output high after reset edge");
        end
    end

    // R2 / R7: every rise of the output follows an armed edge.
    assert_rise_from_armed_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_out) |-> $past(rise && arm));

    // R3: an expired hold count ends the pulse unless an extend-mode edge reloads it.
    assert_hold_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out && hold_zero && !(rise && arm && retrig)) |=> !ctrl_out);

    // R4: an armed edge in extend mode keeps the output high.
    assert_retrig_extends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out && rise && arm && retrig) |=> ctrl_out);

    // R8: a running hold count keeps the output high whatever the arm input does.
    assert_hold_persists_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out && !hold_zero) |=> ctrl_out);

    // R6: a pending lockout count keeps the output low.
    assert_lockout_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_out && !lock_zero) |=> !ctrl_out);

    // R9: even a zero lockout gives at least one low cycle after a fall.
    assert_min_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_out) |=> !ctrl_out);

endmodule

bind retrig_lockout_ctrl rlc_checker i_rlc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_out  (ctrl_out),
    .rise      (trig_rise),
    .arm       (arm_in),
    .retrig    (retrig_mode),
    .hold_zero (hold_zero),
    .lock_zero (lock_zero)
);

// File: tb/test_retrig_lockout_ctrl.sv
// Scoreboard bench: driver code pushes expected pulses (start cycle, length)
// into a queue; a monitor measures each output pulse and compares it.
module test_retrig_lockout_ctrl;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    start;
        int    len;
        string tag_start;
        string tag_len;
    } pulse_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        arm_in = 1'b1;
    logic        retrig_mode = 1'b0;
    logic [15:0] hold_cycles = 16'd4;
    logic [15:0] lock_cycles = 16'd4;
    logic        ctrl_out;

    int     cyc = 0;
    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;
    pulse_t exp_q[$];

    retrig_lockout_ctrl i_retrig_lockout_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .arm_in      (arm_in),
        .retrig_mode (retrig_mode),
        .hold_cycles (hold_cycles),
        .lock_cycles (lock_cycles),
        .ctrl_out    (ctrl_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int s, input int l, input string ts, input string tl);
        pulse_t p;
        p.start = s; p.len = l; p.tag_start = ts; p.tag_len = tl;
        exp_q.push_back(p);
    endtask

    task automatic check_low(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ctrl_out) seen = 1;
        end
        check(seen == 0, req, seen, 0);
    endtask

    // Monitor: measure each output pulse and compare with the queue head.
    int  rise_at = 0;
    bit  prev_out = 1'b0;
    always @(negedge clk) begin
        if (ctrl_out && !prev_out) begin
            rise_at = cyc;
        end else if (!ctrl_out && prev_out) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected pulse", cyc - rise_at, 0);
            end else begin
                pulse_t p;
                p = exp_q.pop_front();
                check(rise_at == p.start, p.tag_start, rise_at, p.start);
                check((cyc - rise_at) == p.len, p.tag_len, cyc - rise_at, p.len);
            end
        end
        prev_out = ctrl_out;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int c;
        // R1: reset holds output low even with trigger high.
        trig_in = 1'b1;
        tick(3);
        check(ctrl_out == 1'b0, "R1", ctrl_out, 0);
        trig_in = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(4);

        // R3: extend mode, single edge, plain hold length.
        retrig_mode = 1'b1; hold_cycles = 16'd7; lock_cycles = 16'd4;
        c = cyc; trig_in = 1'b1; push(c + 3, 7, "R2", "R3");
        tick(2); trig_in = 1'b0;
        tick(25);

        // R5: fixed mode, edge during pulse ignored.
        retrig_mode = 1'b0; hold_cycles = 16'd5;
        c = cyc; trig_in = 1'b1; push(c + 3, 5, "R2", "R5");
        tick(2); trig_in = 1'b0;
        tick(2); trig_in = 1'b1;
        tick(2); trig_in = 1'b0;
        tick(25);

        // R4: extend mode, two retriggers, the second in the last high cycle.
        retrig_mode = 1'b1; hold_cycles = 16'd6;
        c = cyc; trig_in = 1'b1; push(c + 3, 16, "R2", "R4");
        tick(2); trig_in = 1'b0;
        tick(2); trig_in = 1'b1;
        tick(2); trig_in = 1'b0;
        tick(4); trig_in = 1'b1;
        tick(2); trig_in = 1'b0;
        tick(40);

        // R6: edge acted on in last lockout cycle is rejected.
        retrig_mode = 1'b0; hold_cycles = 16'd3; lock_cycles = 16'd8;
        c = cyc; trig_in = 1'b1; push(c + 3, 3, "R2", "R3");
        tick(2); trig_in = 1'b0;
        tick(9); trig_in = 1'b1;
        check_low(12, "R6");
        trig_in = 1'b0;
        tick(20);

        // R6: edge acted on in first cycle after lockout is accepted.
        c = cyc; trig_in = 1'b1; push(c + 3, 3, "R2", "R3");
        tick(2); trig_in = 1'b0;
        tick(10); trig_in = 1'b1; push(c + 15, 3, "R6", "R6");
        tick(2); trig_in = 1'b0;
        tick(30);

        // R7 / R10: disarmed edge discarded, later arming and held level do nothing.
        arm_in = 1'b0;
        trig_in = 1'b1;
        check_low(10, "R7");
        arm_in = 1'b1;
        check_low(10, "R10");
        trig_in = 1'b0;
        tick(3);
        c = cyc; trig_in = 1'b1; push(c + 3, 3, "R7", "R3");
        tick(2); trig_in = 1'b0;
        tick(25);

        // R8: disarm during pulse; extend-mode edge while disarmed is ignored.
        retrig_mode = 1'b1; hold_cycles = 16'd6; lock_cycles = 16'd4;
        c = cyc; trig_in = 1'b1; push(c + 3, 6, "R2", "R8");
        tick(2); trig_in = 1'b0;
        tick(1); arm_in = 1'b0;
        tick(2); trig_in = 1'b1;
        tick(2); trig_in = 1'b0;
        tick(20);
        arm_in = 1'b1;

        // R9: zero counts act as one cycle each.
        retrig_mode = 1'b0; hold_cycles = 16'd0; lock_cycles = 16'd0;
        c = cyc; trig_in = 1'b1; push(c + 3, 1, "R9", "R9");
        tick(1); trig_in = 1'b0;
        tick(2); trig_in = 1'b1; push(c + 6, 1, "R9", "R9");
        tick(2); trig_in = 1'b0;
        tick(20);

        // R1: reset during a pulse clears it; a new edge works right away.
        hold_cycles = 16'd20; lock_cycles = 16'd10;
        c = cyc; trig_in = 1'b1; push(c + 3, 3, "R2", "R1");
        tick(5); rst_n = 1'b0; trig_in = 1'b0;
        tick(1);
        check(ctrl_out == 1'b0, "R1", ctrl_out, 0);
        tick(2); rst_n = 1'b1;
        check_low(4, "R1");
        hold_cycles = 16'd4;
        c = cyc; trig_in = 1'b1; push(c + 3, 4, "R1", "R3");
        tick(2); trig_in = 1'b0;
        tick(20);

        check(exp_q.size() == 0, "scoreboard", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule